// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block translates local bus addresses into downstream bus addresses for a transaction generator. It holds eight outbound translation regions. Each region has a 64-bit base, a limit, a 64-bit target and a transaction kind code. A request address that falls inside an enabled region comes out as the target plus the offset of the address from the region base. The response also carries the region's kind code and a hit flag. An address that matches no enabled region comes back unchanged with the memory kind and the hit flag low.

Software programs the regions through a small indexed window. A selector word chooses a bank and a region number, and the per-region words at fixed offsets then read or write that region. The bank bit picks either the outbound regions, which drive translation, or a second set of eight inbound regions. The inbound regions are stored for readback only. A widen flag in the first control word lets the limit compare use its own upper 32 bits, so one region can span more than 4 GiB. Configuration-kind regions carry bus, device and function numbers in the target, at bits 20, 15 and 12. With a 4 KiB window, the low 12 request bits pass straight into the translated address.

Lookups use a valid/ready handshake on the request and response sides, and a response appears one cycle after a request is accepted.

Top module: `xlat_unit`

## Requirements
- R1: After reset, no response is valid, every region is disabled, and every window word of both banks reads zero.
- R2: The selector word is at byte offset 0x00. Bit 31 selects the bank (1 inbound, 0 outbound), bits [7:0] hold the region number, and all other bits read back as zero.
- R3: Per-region words sit at these byte offsets, for the bank and region in the selector:
  - 0x04 control-1: bits [4:0] hold the kind code (0x0 memory, 0x2 I/O, 0x4 configuration type 0, 0x5 configuration type 1) and bit 13 is the widen flag.
  - 0x08 control-2: bit 31 is the enable.
  - 0x0C base low, 0x10 base high, 0x14 limit low, 0x20 limit high, 0x18 target low, 0x1C target high.

  Only the named bits are stored, and each word reads back exactly what was stored. In particular, after a write that sets the enable, bit 31 of control-2 reads 1.
- R4: When the selector's region number is 8 or more, every per-region word reads zero and writes to them change nothing.
- R5: Inbound-bank writes are stored and read back but never affect translation.
- R6: A region matches addresses from base up to limit inclusive. The limit is {base high, limit low} when widen is clear, and {limit high, limit low} when widen is set.
- R7: On a hit, the translated address is target + (address − base) in 64 bits and the kind is the region's code. For a 4 KiB configuration region this leaves the low 12 request bits unchanged.
- R8: A region whose enable bit is clear never matches.
- R9: When several enabled regions match, the lowest-numbered region is reported and used.
- R10: On a miss, the hit flag is 0, the address is passed through unchanged, and the kind and region outputs are 0.
- R11: The unit is ready whenever no response is held or the held response is being taken. A response is valid in the cycle after acceptance and stays unchanged while it is stalled.
- R12: A window write takes effect for any request accepted at a later clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Window write strobe |
| cfg_addr | input | 6 | Window byte offset (bits [1:0] ignored) |
| cfg_wdata | input | 32 | Window write data |
| cfg_rdata | output | 32 | Window read data for cfg_addr (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_kind | output | 5 | Transaction kind code |
| rsp_hit | output | 1 | An enabled outbound region matched |
| rsp_region | output | 3 | Number of the matching region |

## Verification
The hardest cases to reach are those where the behaviour depends on how regions interact, not on any single region. Examples are an address covered by two enabled regions, a region whose limit-high word is non-zero while widen is clear, and a lookup issued in the cycle right after the write that disables the winning region. The stimulus builds a fixed map of overlapping, disabled, wide and narrow regions. It then probes each region at base−1, base, base+1, the midpoint, the limit and limit+1, and compares every response with an arithmetic model kept in the bench. The stimulus also loads the inbound bank with catch-all regions and writes to out-of-range region numbers, then checks that the same probes give the same results as before.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2 * REG_W;
  localparam int KIND_W   = 5;
  localparam int OFF_W    = 6;
  localparam int IDX_W    = 8;
  localparam int BANKS    = 2;
  localparam int BANK_BIT = 31;
  localparam int WIDE_BIT = 13;
  localparam int EN_BIT   = 31;

  localparam logic [OFF_W-1:0] OFS_SELECT  = 6'h00;
  localparam logic [OFF_W-1:0] OFS_CTL1    = 6'h04;
  localparam logic [OFF_W-1:0] OFS_CTL2    = 6'h08;
  localparam logic [OFF_W-1:0] OFS_BASE_LO = 6'h0C;
  localparam logic [OFF_W-1:0] OFS_BASE_HI = 6'h10;
  localparam logic [OFF_W-1:0] OFS_LIM_LO  = 6'h14;
  localparam logic [OFF_W-1:0] OFS_TGT_LO  = 6'h18;
  localparam logic [OFF_W-1:0] OFS_TGT_HI  = 6'h1C;
  localparam logic [OFF_W-1:0] OFS_LIM_HI  = 6'h20;

  // Stored state of one region, exactly the bits software can see.
  typedef struct packed {
    logic              en;
    logic              wide;
    logic [KIND_W-1:0] kind;
    logic [REG_W-1:0]  base_lo;
    logic [REG_W-1:0]  base_hi;
    logic [REG_W-1:0]  lim_lo;
    logic [REG_W-1:0]  lim_hi;
    logic [REG_W-1:0]  tgt_lo;
    logic [REG_W-1:0]  tgt_hi;
  } region_regs_t;

  // Decoded view used by the lookup path.
  typedef struct packed {
    logic              en;
    logic [KIND_W-1:0] kind;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ADDR_W-1:0] target;
  } region_view_t;

endpackage

// File: rtl/xlat_regbank.sv
module xlat_regbank
  import xlat_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [OFF_W-1:0]      cfg_addr,
  input  logic [REG_W-1:0]      cfg_wdata,
  output logic [REG_W-1:0]      cfg_rdata,
  output region_view_t          out_view [NREG]
);

  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [IDX_W-1:0] NREG_L = IDX_W'(NREG);

  logic [OFF_W-1:0] word_off;
  logic             sel_ok;
  logic [SEL_W-1:0] idx_sel;

  // selector word
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             bank_q, bank_d;
  logic             sel_we;

  assign word_off = {cfg_addr[OFF_W-1:2], 2'b00};
  assign sel_we   = cfg_we && (word_off == OFS_SELECT);
  assign sel_ok   = (idx_q < NREG_L);
  assign idx_sel  = idx_q[SEL_W-1:0];

  always_comb begin
    idx_d  = cfg_wdata[IDX_W-1:0];
    bank_d = cfg_wdata[BANK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      bank_q <= 1'b0;
    end else if (sel_we) begin
      idx_q  <= idx_d;
      bank_q <= bank_d;
    end
  end

  region_regs_t bank_arr [BANKS][NREG];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      region_regs_t q, nxt;
      logic         wsel;

      assign wsel = cfg_we && sel_ok && (bank_q == 1'(b)) && (idx_q == IDX_W'(r));

      always_comb begin
        nxt = q;
        case (word_off)
          OFS_CTL1: begin
            nxt.kind = cfg_wdata[KIND_W-1:0];
            nxt.wide = cfg_wdata[WIDE_BIT];
          end
          OFS_CTL2:    nxt.en      = cfg_wdata[EN_BIT];
          OFS_BASE_LO: nxt.base_lo = cfg_wdata;
          OFS_BASE_HI: nxt.base_hi = cfg_wdata;
          OFS_LIM_LO:  nxt.lim_lo  = cfg_wdata;
          OFS_LIM_HI:  nxt.lim_hi  = cfg_wdata;
          OFS_TGT_LO:  nxt.tgt_lo  = cfg_wdata;
          OFS_TGT_HI:  nxt.tgt_hi  = cfg_wdata;
          default: ;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (wsel) begin
          q <= nxt;
        end
      end

      assign bank_arr[b][r] = q;
    end
  end

  // outbound view for translation; inbound bank is readback only
  for (genvar r = 0; r < NREG; r++) begin : g_view
    region_regs_t o;
    assign o = bank_arr[0][r];
    assign out_view[r].en     = o.en;
    assign out_view[r].kind   = o.kind;
    assign out_view[r].base   = {o.base_hi, o.base_lo};
    assign out_view[r].limit  = o.wide ? {o.lim_hi, o.lim_lo} : {o.base_hi, o.lim_lo};
    assign out_view[r].target = {o.tgt_hi, o.tgt_lo};
  end

  region_regs_t cur;
  assign cur = bank_arr[bank_q][idx_sel];

  always_comb begin
    cfg_rdata = '0;
    case (word_off)
      OFS_SELECT: begin
        cfg_rdata[BANK_BIT]    = bank_q;
        cfg_rdata[IDX_W-1:0]   = idx_q;
      end
      OFS_CTL1: if (sel_ok) begin
        cfg_rdata[KIND_W-1:0]  = cur.kind;
        cfg_rdata[WIDE_BIT]    = cur.wide;
      end
      OFS_CTL2:    if (sel_ok) cfg_rdata[EN_BIT] = cur.en;
      OFS_BASE_LO: if (sel_ok) cfg_rdata = cur.base_lo;
      OFS_BASE_HI: if (sel_ok) cfg_rdata = cur.base_hi;
      OFS_LIM_LO:  if (sel_ok) cfg_rdata = cur.lim_lo;
      OFS_LIM_HI:  if (sel_ok) cfg_rdata = cur.lim_hi;
      OFS_TGT_LO:  if (sel_ok) cfg_rdata = cur.tgt_lo;
      OFS_TGT_HI:  if (sel_ok) cfg_rdata = cur.tgt_hi;
      default:     cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int NREG = 8
) (
  input  region_view_t      view [NREG],
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit_vec
);

  for (genvar r = 0; r < NREG; r++) begin : g_cmp
    logic above_base, below_lim;
    assign above_base = (addr >= view[r].base);
    assign below_lim  = (addr <= view[r].limit);
    assign hit_vec[r] = view[r].en && above_base && below_lim;
  end

endmodule

// File: rtl/xlat_select.sv
module xlat_select
  import xlat_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int SEL_W = 3
) (
  input  region_view_t      view [NREG],
  input  logic [NREG-1:0]   hit_vec,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SEL_W-1:0]  region,
  output logic [KIND_W-1:0] kind,
  output logic [ADDR_W-1:0] xaddr
);

  logic [SEL_W-1:0] win;

  // lowest index wins: scan downward, last assignment sticks
  always_comb begin
    win = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_vec[i]) win = SEL_W'(i);
    end
  end

  always_comb begin
    hit = |hit_vec;
    if (hit) begin
      region = win;
      kind   = view[win].kind;
      xaddr  = view[win].target + (addr - view[win].base);
    end else begin
      region = '0;
      kind   = '0;
      xaddr  = addr;
    end
  end

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter  int NREG  = 8,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_addr,
  output logic [4:0]        rsp_kind,
  output logic              rsp_hit,
  output logic [SEL_W-1:0]  rsp_region
);

  region_view_t      view [NREG];
  logic [NREG-1:0]   hit_vec;
  logic              lk_hit;
  logic [SEL_W-1:0]  lk_region;
  logic [KIND_W-1:0] lk_kind;
  logic [ADDR_W-1:0] lk_addr;

  xlat_regbank #(.NREG(NREG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .out_view (view)
  );

  xlat_match #(.NREG(NREG)) u_match (
    .view   (view),
    .addr   (req_addr),
    .hit_vec(hit_vec)
  );

  xlat_select #(.NREG(NREG), .SEL_W(SEL_W)) u_sel (
    .view   (view),
    .hit_vec(hit_vec),
    .addr   (req_addr),
    .hit    (lk_hit),
    .region (lk_region),
    .kind   (lk_kind),
    .xaddr  (lk_addr)
  );

  // response stage
  logic              vld_q, vld_d;
  logic              hit_q;
  logic [SEL_W-1:0]  reg_q;
  logic [KIND_W-1:0] kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;

  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    vld_d = vld_q;
    if (accept)         vld_d = 1'b1;
    else if (rsp_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      reg_q  <= '0;
      kind_q <= '0;
      addr_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (accept) begin
        hit_q  <= lk_hit;
        reg_q  <= lk_region;
        kind_q <= lk_kind;
        addr_q <= lk_addr;
      end
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_hit    = hit_q;
  assign rsp_region = reg_q;
  assign rsp_kind   = kind_q;
  assign rsp_addr   = addr_q;

endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
  parameter int NREG  = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [63:0]      req_addr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [63:0]      rsp_addr,
  input logic [4:0]       rsp_kind,
  input logic             rsp_hit,
  input logic [SEL_W-1:0] rsp_region
);

  logic [63:0] cap_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cap_addr <= '0;
    else if (req_valid && req_ready)  cap_addr <= req_addr;
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  p_ready_when_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  p_accept_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_hit)
                                  && $stable(rsp_kind) && $stable(rsp_region));

  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

  p_miss_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == cap_addr) && (rsp_kind == 5'd0)
                                && (rsp_region == '0));

endmodule

bind xlat_unit xlat_unit_chk #(.NREG(NREG), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_kind  (rsp_kind),
  .rsp_hit   (rsp_hit),
  .rsp_region(rsp_region)
);

// File: tb/xlat_unit_test.sv
module xlat_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [63:0] rsp_addr;
  logic [4:0]  rsp_kind;
  logic        rsp_hit;
  logic [2:0]  rsp_region;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_kind(rsp_kind), .rsp_hit(rsp_hit), .rsp_region(rsp_region)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model: [bank][region][field], field = offset/4 - 1
  logic [31:0] m_regs [2][8][8];
  logic        m_bank;
  logic [7:0]  m_idx;

  logic [63:0] rb_base [8];
  logic [63:0] rb_size [8];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] field_mask(input int f);
    if (f == 0) return 32'h0000_201F;
    if (f == 1) return 32'h8000_0000;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    int f;
    if (a == 6'h00) return {m_bank, 23'd0, m_idx};
    if (a < 6'h04 || a > 6'h20) return 32'd0;
    if (m_idx >= 8'd8) return 32'd0;
    f = int'(a >> 2) - 1;
    return m_regs[m_bank][m_idx[2:0]][f];
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++)
        for (int f = 0; f < 8; f++) m_regs[b][r][f] = 32'd0;
    m_bank = 1'b0;
    m_idx  = 8'd0;
  endtask

  task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
    int f;
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    if (a == 6'h00) begin
      m_bank = d[31];
      m_idx  = d[7:0];
    end else if (a >= 6'h04 && a <= 6'h20 && m_idx < 8'd8) begin
      f = int'(a >> 2) - 1;
      m_regs[m_bank][m_idx[2:0]][f] = d & field_mask(f);
    end
  endtask

  task automatic cfg_rd_chk(input logic [5:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(cfg_rdata == e, req, {32'd0, cfg_rdata}, {32'd0, e});
  endtask

  task automatic prog(input bit bank, input int idx, input logic [4:0] kind, input bit wide,
                      input logic [63:0] base, input logic [63:0] size,
                      input logic [63:0] target, input bit en);
    logic [63:0] lim;
    lim = base + size - 64'd1;
    cfg_wr(6'h00, {bank, 23'd0, 8'(idx)});
    cfg_wr(6'h08, 32'd0);
    cfg_wr(6'h0C, base[31:0]);
    cfg_wr(6'h10, base[63:32]);
    cfg_wr(6'h14, lim[31:0]);
    cfg_wr(6'h20, lim[63:32]);
    cfg_wr(6'h18, target[31:0]);
    cfg_wr(6'h1C, target[63:32]);
    cfg_wr(6'h04, {18'd0, wide, 8'd0, kind});
    cfg_wr(6'h08, {en, 31'd0});
  endtask

  function automatic void model_lookup(input logic [63:0] a, output bit hit, output logic [2:0] rg,
                                       output logic [4:0] k, output logic [63:0] x);
    logic [63:0] b, l, t;
    hit = 1'b0; rg = 3'd0; k = 5'd0; x = a;
    for (int i = 7; i >= 0; i--) begin
      b = {m_regs[0][i][3], m_regs[0][i][2]};
      l = m_regs[0][i][0][13] ? {m_regs[0][i][7], m_regs[0][i][4]}
                              : {m_regs[0][i][3], m_regs[0][i][4]};
      t = {m_regs[0][i][6], m_regs[0][i][5]};
      if (m_regs[0][i][1][31] && a >= b && a <= l) begin
        hit = 1'b1; rg = 3'(i); k = m_regs[0][i][0][4:0]; x = t + (a - b);
      end
    end
  endfunction

  task automatic lookup(input logic [63:0] a, input string req);
    bit eh; logic [2:0] er; logic [4:0] ek; logic [63:0] ex;
    model_lookup(a, eh, er, ek, ex);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " valid"}, {63'd0, rsp_valid}, 64'd1);
    chk(rsp_hit == eh, {req, " hit"}, {63'd0, rsp_hit}, {63'd0, eh});
    chk(rsp_region == er, {req, " region"}, {61'd0, rsp_region}, {61'd0, er});
    chk(rsp_kind == ek, {req, " kind"}, {59'd0, rsp_kind}, {59'd0, ek});
    chk(rsp_addr == ex, {req, " addr"}, rsp_addr, ex);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 8; i++) begin
      lookup(rb_base[i] - 64'd1, req);
      lookup(rb_base[i], req);
      lookup(rb_base[i] + 64'd1, req);
      lookup(rb_base[i] + (rb_size[i] >> 1), req);
      lookup(rb_base[i] + rb_size[i] - 64'd1, req);
      lookup(rb_base[i] + rb_size[i], req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] tmp;
    logic [63:0] exp_a, exp_b;
    bit eh; logic [2:0] er; logic [4:0] ek;

    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    chk(req_ready == 1'b1, "R11 ready when empty", {63'd0, req_ready}, 64'd1);
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 10; r++) begin
        cfg_wr(6'h00, {b[0], 23'd0, 8'(r)});
        cfg_rd_chk(6'h00, "R2 selector readback");
        for (int o = 1; o <= 8; o++) cfg_rd_chk(6'(o * 4), "R1 reset readback zero");
      end

    // R2 selector bits
    cfg_wr(6'h00, 32'hFFFF_FFFF);
    cfg_rd_chk(6'h00, "R2 selector only bank and index bits");
    cfg_wr(6'h00, 32'h7FFF_FF03);
    cfg_rd_chk(6'h00, "R2 selector outbound");

    // R3 field storage and masks, both banks
    for (int b = 0; b < 2; b++) begin
      cfg_wr(6'h00, {b[0], 23'd0, 8'd3 + 8'(b)});
      for (int o = 1; o <= 8; o++) cfg_wr(6'(o * 4), 32'hFFFF_FFFF);
      for (int o = 1; o <= 8; o++) cfg_rd_chk(6'(o * 4), "R3 all-ones readback");
      for (int o = 1; o <= 8; o++) cfg_wr(6'(o * 4), 32'hA5C3_3C5A ^ 32'(o));
      for (int o = 1; o <= 8; o++) cfg_rd_chk(6'(o * 4), "R3 pattern readback");
      for (int o = 1; o <= 8; o++) cfg_wr(6'(o * 4), 32'd0);
    end
    cfg_wr(6'h00, 32'd2);
    cfg_wr(6'h08, 32'h8000_0000);
    cfg_rd_chk(6'h08, "R3 enable reads back set");
    cfg_wr(6'h08, 32'd0);

    // R4 out-of-range index
    cfg_wr(6'h00, 32'd9);
    for (int o = 1; o <= 8; o++) cfg_wr(6'(o * 4), 32'hFFFF_FFFF);
    for (int o = 1; o <= 8; o++) cfg_rd_chk(6'(o * 4), "R4 index 9 reads zero");
    lookup(64'h0, "R4 R10 miss after ignored write");
    lookup(64'hFFFF_FFFF_FFFF_FFFF, "R4 R10 miss high address");
    for (int r = 0; r < 8; r++) begin
      cfg_wr(6'h00, 8'(r));
      cfg_rd_chk(6'h08, "R4 real regions untouched");
    end

    // outbound map
    rb_base[0] = 64'h0000_0000_4000_0000; rb_size[0] = 64'h1000_0000;
    rb_base[1] = 64'h0000_0000_4800_0000; rb_size[1] = 64'h0100_0000;
    rb_base[2] = 64'h0000_0000_8000_0000; rb_size[2] = 64'h1000;
    rb_base[3] = 64'h0000_0001_0000_0000; rb_size[3] = 64'h1000;
    rb_base[4] = 64'h0000_0002_0000_0000; rb_size[4] = 64'h2_0000_0000;
    rb_base[5] = 64'h0000_0005_F000_0000; rb_size[5] = 64'h1000_0000;
    rb_base[6] = 64'h0000_0000_C000_0000; rb_size[6] = 64'h1000_0000;
    rb_base[7] = 64'h0000_0000_D000_0000; rb_size[7] = 64'h10;
    prog(1'b0, 0, 5'h0, 1'b0, rb_base[0], rb_size[0], 64'h0000_0090_4000_0000, 1'b1);
    prog(1'b0, 1, 5'h2, 1'b0, rb_base[1], rb_size[1], 64'h1234_0000_0000_0000, 1'b1);
    prog(1'b0, 2, 5'h4, 1'b0, rb_base[2], rb_size[2], 64'h0000_0000_0032_A000, 1'b1);
    prog(1'b0, 3, 5'h5, 1'b0, rb_base[3], rb_size[3], 64'h0000_0000_0070_8000, 1'b1);
    prog(1'b0, 4, 5'h0, 1'b1, rb_base[4], rb_size[4], 64'h0000_0100_0000_0000, 1'b1);
    prog(1'b0, 5, 5'h2, 1'b0, rb_base[5], rb_size[5], 64'hFFFF_FFFF_F000_0000, 1'b1);
    prog(1'b0, 6, 5'h0, 1'b0, rb_base[6], rb_size[6], 64'h0000_0077_0000_0000, 1'b0);
    prog(1'b0, 7, 5'h2, 1'b0, rb_base[7], rb_size[7], 64'h0000_0000_0000_1000, 1'b1);
    cfg_wr(6'h00, 32'd5);
    cfg_wr(6'h20, 32'd7);      // limit high ignored while widen clear

    sweep("R6 R7 R8 R9 R10 range sweep");

    // explicit corner checks
    model_lookup(64'h0000_0000_8000_0ABC, eh, er, ek, exp_a);
    chk(exp_a == 64'h0000_0000_0032_AABC, "R7 model cfg low bits", exp_a, 64'h0000_0000_0032_AABC);
    lookup(64'h0000_0000_8000_0ABC, "R7 config low 12 bits pass through");
    chk(rsp_addr == 64'h0000_0000_0032_AABC, "R7 config bus/dev/fn target", rsp_addr, 64'h0000_0000_0032_AABC);
    lookup(64'h0000_0003_8000_0000, "R6 wide region above 4 GiB");
    chk(rsp_hit && rsp_region == 3'd4, "R6 wide hit region 4", {61'd0, rsp_region}, 64'd4);
    lookup(64'h0000_0006_0000_0000, "R6 narrow limit ignores limit high");
    chk(!rsp_hit, "R6 narrow miss", {63'd0, rsp_hit}, 64'd0);
    lookup(64'h0000_0000_4880_0000, "R9 overlap");
    chk(rsp_region == 3'd0, "R9 lowest region wins", {61'd0, rsp_region}, 64'd0);
    lookup(64'h0000_0000_C000_0000, "R8 disabled region");
    chk(!rsp_hit, "R8 disabled never matches", {63'd0, rsp_hit}, 64'd0);

    // R12 write then immediate lookup
    cfg_wr(6'h00, 32'd0);
    cfg_wr(6'h08, 32'd0);
    lookup(64'h0000_0000_4880_0000, "R12 disable visible next lookup");
    chk(rsp_region == 3'd1, "R12 region 1 now wins", {61'd0, rsp_region}, 64'd1);
    cfg_wr(6'h08, 32'h8000_0000);
    lookup(64'h0000_0000_4880_0000, "R12 re-enable visible");

    // R5 inbound bank
    for (int r = 0; r < 8; r++)
      prog(1'b1, r, 5'h4, 1'b1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00AB_0000_0000, 1'b1);
    for (int o = 1; o <= 8; o++) cfg_rd_chk(6'(o * 4), "R5 inbound readback");
    sweep("R5 inbound bank has no effect");

    // R11 stall
    tmp = 64'h0000_0000_4000_1234;
    model_lookup(tmp, eh, er, ek, exp_a);
    model_lookup(64'h0000_0000_D000_0008, eh, er, ek, exp_b);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = tmp;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid, "R11 valid one cycle after accept", {63'd0, rsp_valid}, 64'd1);
    chk(!req_ready, "R11 not ready while stalled", {63'd0, req_ready}, 64'd0);
    req_addr = 64'h0000_0000_D000_0008;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_addr == exp_a, "R11 held response stable", rsp_addr, exp_a);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_addr == exp_b, "R11 second request after release", rsp_addr, exp_b);
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R11 drains when taken", {63'd0, rsp_valid}, 64'd0);

    // R1 reset mid-run
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cfg_rd_chk(6'h00, "R1 selector cleared by reset");
    for (int o = 1; o <= 8; o++) cfg_rd_chk(6'(o * 4), "R1 region 0 cleared by reset");
    lookup(64'h0000_0000_4000_0000, "R1 R10 all disabled after reset");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule